// File: doc/BRIEF.md
# Picosecond Delay to Element Count Converter

This block turns a requested pad delay into the number of coarse and fine delay elements a pad delay line must switch in, and forms the 32-bit configuration word that carries those counts. A request has two parts. The gnostic part is split against fixed element sizes of 920 ps (coarse) and 60 ps (fine). The agnostic part is split against coarse and fine element sizes measured by a calibration step elsewhere. Fine parts are kept in tenths of an element until they are summed. If the summed fine count comes out above 22, the total delay is rebuilt from both counts and split again against the calibrated sizes.

A host presents both delays and both calibrated element sizes, then pulses `start`. A small state machine runs every division, one after another, on one shared shift-subtract divider. When the result is ready, `done` pulses for one cycle. In that same cycle the counts, the overflow flags and the configuration word are valid, and they hold until the next result. Computing the calibration values and writing the word to the pad belong to other blocks.

Top module: `delay_elem_conv`

## Requirements
- R1: The gnostic coarse count is gno_ps / 920. The gnostic fine part, in tenths, is ((gno_ps mod 920) * 10) / 60. All divisions truncate.
- R2: The agnostic coarse count is agn_ps / coarse_pe. The agnostic fine part, in tenths, is ((agn_ps mod coarse_pe) * 10) / fine_pe. All divisions truncate.
- R3: The coarse count is the sum of the two coarse counts. The fine count is the sum of the two fine tenths, divided by 10 with truncation.
- R4: When the fine count from R3 is greater than 22, total = coarse * coarse_pe + fine * fine_pe. Then coarse = total / coarse_pe and fine = (total mod coarse_pe) / fine_pe. A fine count of exactly 22 is kept as it is.
- R5: A count above 31 is reduced to its low 5 bits. The block then raises coarse_ovf or fine_ovf, whichever belongs to that count.
- R6: In cfg_word, bits 17:12 hold 6'h29, bit 10 (lock) is 0, bits 9:5 hold the coarse count, bits 4:0 hold the fine count, and every other bit is 0.
- R7: done is high for exactly one cycle per accepted start. The counts do not change in any cycle without done.
- R8: A start that arrives while a conversion is running is ignored. The inputs are captured only when a start is accepted.
- R9: Both overflow flags are valid with done. They clear in the cycle after the next accepted start.
- R10: After reset, done, both counts and both flags are 0, and cfg_word holds only the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| agn_ps | input | DELAY_W | Agnostic delay in ps |
| gno_ps | input | DELAY_W | Gnostic delay in ps |
| coarse_pe | input | CAL_W | Calibrated coarse element delay, nonzero |
| fine_pe | input | CAL_W | Calibrated fine element delay, nonzero |
| coarse_cnt | output | 5 | Coarse element count |
| fine_cnt | output | 5 | Fine element count |
| cfg_word | output | 32 | Assembled configuration word |
| coarse_ovf | output | 1 | Coarse count exceeded 5 bits |
| fine_ovf | output | 1 | Fine count exceeded 5 bits |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default widths: 16-bit delays and 16-bit calibrated sizes. With 16-bit delays, a gnostic request near 65535 ps produces a coarse count of 71 and so wraps the 5-bit field. A fine element size of 2 ps drives the fine tenths far past 22, which exercises both the re-split path and the fine overflow. Chosen calibrated sizes put the summed fine count at exactly 22 and at 23, and one request is interrupted by a second start in the middle of its run.

// File: rtl/delay_conv_pkg.sv
package delay_conv_pkg;

    localparam int CNT_W        = 5;
    localparam int GN_COARSE_PS = 920;
    localparam int GN_FINE_PS   = 60;
    localparam int TENTHS       = 10;
    localparam int FINE_LIMIT   = 22;
    localparam logic [5:0] WORD_SIG = 6'h29;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_G_CRS,
        ST_G_FIN,
        ST_A_CRS,
        ST_A_FIN,
        ST_SUM,
        ST_RE_CRS,
        ST_RE_FIN,
        ST_FINISH
    } conv_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] coarse;
        logic [CNT_W-1:0] fine;
    } elem_cnt_t;

    // Field layout of the pad configuration word.
    function automatic logic [31:0] build_word(elem_cnt_t cnt);
        logic [31:0] w;
        w        = '0;
        w[17:12] = WORD_SIG;
        w[10]    = 1'b0;
        w[9:5]   = cnt.coarse;
        w[4:0]   = cnt.fine;
        return w;
    endfunction

endpackage

// File: rtl/dconv_divider.sv
module dconv_divider #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         valid,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, valid_q;
    logic [W:0]    trial, diff;
    logic          ge;

    always_comb begin
        trial = {acc_q, quo_q[W-1]};
        ge    = trial >= {1'b0, dvs_q};
        diff  = trial - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go && !busy_q) begin
                acc_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                acc_q <= ge ? diff[W-1:0] : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign valid     = valid_q;
    assign quotient  = quo_q;
    assign remainder = acc_q;

endmodule

// File: rtl/dconv_pack.sv
module dconv_pack
    import delay_conv_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] crs_full,
    input  logic [ACC_W-1:0] fin_full,
    output elem_cnt_t        fld,
    output logic             ovf_c,
    output logic             ovf_f
);
    always_comb begin
        fld.coarse = crs_full[CNT_W-1:0];
        fld.fine   = fin_full[CNT_W-1:0];
        ovf_c      = |crs_full[ACC_W-1:CNT_W];
        ovf_f      = |fin_full[ACC_W-1:CNT_W];
    end
endmodule

// File: rtl/delay_elem_conv.sv
module delay_elem_conv
    import delay_conv_pkg::*;
#(
    parameter int DELAY_W = 16,
    parameter int CAL_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DELAY_W-1:0] agn_ps,
    input  logic [DELAY_W-1:0] gno_ps,
    input  logic [CAL_W-1:0]   coarse_pe,
    input  logic [CAL_W-1:0]   fine_pe,
    output logic [CNT_W-1:0]   coarse_cnt,
    output logic [CNT_W-1:0]   fine_cnt,
    output logic [31:0]        cfg_word,
    output logic               coarse_ovf,
    output logic               fine_ovf,
    output logic               done
);
    localparam int DW = DELAY_W + CAL_W + 8;

    conv_state_e        state_q;
    logic               wait_q;
    logic [DELAY_W-1:0] a_q, g_q;
    logic [CAL_W-1:0]   cpe_q, fpe_q;
    logic [DW-1:0]      g_crs_q, g_ften_q, a_crs_q, a_ften_q;
    logic [DW-1:0]      crs_q, fin_q, rem_q;
    elem_cnt_t          cnt_q;
    logic               ovf_c_q, ovf_f_q, done_q;

    logic               div_go, div_busy, div_valid;
    logic [DW-1:0]      div_num, div_den, div_quo, div_rem;
    elem_cnt_t          fld;
    logic               fld_ovf_c, fld_ovf_f;
    logic               busy;

    assign busy = (state_q != ST_IDLE);

    // Operand selection for the shared divider
    always_comb begin
        div_num = '0;
        div_den = DW'(1);
        unique case (state_q)
            ST_G_CRS:  begin div_num = DW'(g_q);                 div_den = DW'(GN_COARSE_PS); end
            ST_G_FIN:  begin div_num = rem_q * DW'(TENTHS);      div_den = DW'(GN_FINE_PS);   end
            ST_A_CRS:  begin div_num = DW'(a_q);                 div_den = DW'(cpe_q);        end
            ST_A_FIN:  begin div_num = rem_q * DW'(TENTHS);      div_den = DW'(fpe_q);        end
            ST_SUM:    begin div_num = g_ften_q + a_ften_q;      div_den = DW'(TENTHS);       end
            ST_RE_CRS: begin div_num = crs_q * DW'(cpe_q) + fin_q * DW'(fpe_q);
                             div_den = DW'(cpe_q); end
            ST_RE_FIN: begin div_num = rem_q;                    div_den = DW'(fpe_q);        end
            default:   begin div_num = '0;                       div_den = DW'(1);            end
        endcase
        div_go = busy && (state_q != ST_FINISH) && !wait_q;
    end

    dconv_divider #(.W(DW)) i_div (
        .clk       (clk),
        .rst       (rst),
        .go        (div_go),
        .dividend  (div_num),
        .divisor   (div_den),
        .busy      (div_busy),
        .valid     (div_valid),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    dconv_pack #(.ACC_W(DW)) i_pack (
        .crs_full (crs_q),
        .fin_full (fin_q),
        .fld      (fld),
        .ovf_c    (fld_ovf_c),
        .ovf_f    (fld_ovf_f)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wait_q   <= 1'b0;
            a_q      <= '0;
            g_q      <= '0;
            cpe_q    <= '0;
            fpe_q    <= '0;
            g_crs_q  <= '0;
            g_ften_q <= '0;
            a_crs_q  <= '0;
            a_ften_q <= '0;
            crs_q    <= '0;
            fin_q    <= '0;
            rem_q    <= '0;
            cnt_q    <= '0;
            ovf_c_q  <= 1'b0;
            ovf_f_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    a_q     <= agn_ps;
                    g_q     <= gno_ps;
                    cpe_q   <= coarse_pe;
                    fpe_q   <= fine_pe;
                    ovf_c_q <= 1'b0;
                    ovf_f_q <= 1'b0;
                    state_q <= ST_G_CRS;
                end
            end else if (state_q == ST_FINISH) begin
                cnt_q   <= fld;
                ovf_c_q <= fld_ovf_c;
                ovf_f_q <= fld_ovf_f;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else if (!wait_q) begin
                wait_q <= 1'b1;
            end else if (div_valid && !div_busy) begin
                wait_q <= 1'b0;
                unique case (state_q)
                    ST_G_CRS: begin
                        g_crs_q <= div_quo;
                        rem_q   <= div_rem;
                        state_q <= ST_G_FIN;
                    end
                    ST_G_FIN: begin
                        g_ften_q <= div_quo;
                        state_q  <= ST_A_CRS;
                    end
                    ST_A_CRS: begin
                        a_crs_q <= div_quo;
                        rem_q   <= div_rem;
                        state_q <= ST_A_FIN;
                    end
                    ST_A_FIN: begin
                        a_ften_q <= div_quo;
                        state_q  <= ST_SUM;
                    end
                    ST_SUM: begin
                        fin_q   <= div_quo;
                        crs_q   <= g_crs_q + a_crs_q;
                        state_q <= (div_quo > DW'(FINE_LIMIT)) ? ST_RE_CRS : ST_FINISH;
                    end
                    ST_RE_CRS: begin
                        crs_q   <= div_quo;
                        rem_q   <= div_rem;
                        state_q <= ST_RE_FIN;
                    end
                    ST_RE_FIN: begin
                        fin_q   <= div_quo;
                        state_q <= ST_FINISH;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign coarse_cnt = cnt_q.coarse;
    assign fine_cnt   = cnt_q.fine;
    assign cfg_word   = build_word(cnt_q);
    assign coarse_ovf = ovf_c_q;
    assign fine_ovf   = ovf_f_q;
    assign done       = done_q;

endmodule

// File: rtl/dconv_checker.sv
module dconv_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [4:0]  coarse_cnt,
    input logic [4:0]  fine_cnt,
    input logic [31:0] cfg_word,
    input logic        coarse_ovf,
    input logic        fine_ovf
);
    // R7: the result strobe lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: counts move only together with the strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(coarse_cnt) && $stable(fine_cnt)));

    // R8: a strobe only follows a running conversion
    p_done_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R9: an accepted start clears both flags
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!coarse_ovf && !fine_ovf));

    // R6: the word carries the signature, an open lock bit and the counts
    p_word_layout_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[17:12] == 6'h29) && !cfg_word[10] &&
        (cfg_word[9:5] == coarse_cnt) && (cfg_word[4:0] == fine_cnt) &&
        (cfg_word[31:18] == '0) && !cfg_word[11]);
endmodule

bind delay_elem_conv dconv_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .coarse_cnt (coarse_cnt),
    .fine_cnt   (fine_cnt),
    .cfg_word   (cfg_word),
    .coarse_ovf (coarse_ovf),
    .fine_ovf   (fine_ovf)
);

// File: tb/test_delay_elem_conv.sv
module test_delay_elem_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] agn_ps = '0, gno_ps = '0, coarse_pe = 16'd100, fine_pe = 16'd10;
    logic [4:0]  coarse_cnt, fine_cnt;
    logic [31:0] cfg_word;
    logic        coarse_ovf, fine_ovf, done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    delay_elem_conv i_delay_elem_conv (
        .clk(clk), .rst(rst), .start(start),
        .agn_ps(agn_ps), .gno_ps(gno_ps),
        .coarse_pe(coarse_pe), .fine_pe(fine_pe),
        .coarse_cnt(coarse_cnt), .fine_cnt(fine_cnt), .cfg_word(cfg_word),
        .coarse_ovf(coarse_ovf), .fine_ovf(fine_ovf), .done(done)
    );

    // {req, agn, gno, coarse_pe, fine_pe, coarse, fine, ovf_c, ovf_f}
    localparam int NV = 10;
    localparam logic [79:0] VEC [NV] = '{
        {4'd3, 16'd0,    16'd0,     16'd100, 16'd10, 5'd0,  5'd0,  1'b0, 1'b0}, // R3 zero request
        {4'd1, 16'd0,    16'd2000,  16'd100, 16'd10, 5'd2,  5'd2,  1'b0, 1'b0}, // R1 gnostic only
        {4'd2, 16'd1234, 16'd0,     16'd100, 16'd10, 5'd12, 5'd3,  1'b0, 1'b0}, // R2 agnostic only
        {4'd3, 16'd1234, 16'd2000,  16'd100, 16'd10, 5'd14, 5'd6,  1'b0, 1'b0}, // R3 both parts
        {4'd4, 16'd19,   16'd919,   16'd20,  16'd2,  5'd2,  5'd4,  1'b0, 1'b0}, // R4 re-split
        {4'd4, 16'd14,   16'd919,   16'd30,  16'd2,  5'd0,  5'd22, 1'b0, 1'b0}, // R4 exactly 22 kept
        {4'd4, 16'd16,   16'd919,   16'd30,  16'd2,  5'd1,  5'd8,  1'b0, 1'b0}, // R4 23 re-split
        {4'd5, 16'd0,    16'd65535, 16'd100, 16'd10, 5'd7,  5'd3,  1'b1, 1'b0}, // R5 coarse 71
        {4'd5, 16'd499,  16'd0,     16'd500, 16'd2,  5'd0,  5'd25, 1'b0, 1'b1}, // R5 fine 249
        {4'd5, 16'd0,    16'd30000, 16'd100, 16'd10, 5'd0,  5'd9,  1'b1, 1'b0}  // R5 coarse 32
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [4:0] c, input logic [4:0] f);
        return 32'h0002_9000 | (32'(c) << 5) | 32'(f);
    endfunction

    task automatic launch(input logic [15:0] a, input logic [15:0] g,
                          input logic [15:0] cp, input logic [15:0] fp);
        agn_ps = a; gno_ps = g; coarse_pe = cp; fine_pe = fp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk(req, 32'd0, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 counts", {22'd0, coarse_cnt, fine_cnt}, 32'd0);
        chk("R10 flags", {30'd0, coarse_ovf, fine_ovf}, 32'd0);
        chk("R6 reset word", cfg_word, 32'h0002_9000);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[79:76], i);
            launch(v[75:60], v[59:44], v[43:28], v[27:12]);
            wait_done(tag);
            chk(tag, 32'(coarse_cnt), 32'(v[11:7]));
            chk(tag, 32'(fine_cnt), 32'(v[6:2]));
            chk({tag, " R5 flags"}, {30'd0, coarse_ovf, fine_ovf}, {30'd0, v[1:0]});
            chk({tag, " R6 word"}, cfg_word, word_of(v[11:7], v[6:2]));
            @(negedge clk);
            chk({tag, " R7 single"}, 32'(done), 32'd0);
        end

        // R9: flags from the last vector clear on the next accepted start
        chk("R9 flag before", 32'(coarse_ovf), 32'd1);
        launch(16'd0, 16'd2000, 16'd100, 16'd10);
        chk("R9 flags cleared", {30'd0, coarse_ovf, fine_ovf}, 32'd0);
        chk("R7 counts held", {22'd0, coarse_cnt, fine_cnt}, {22'd0, 5'd0, 5'd9});
        wait_done("R9 run");
        chk("R1 after clear", {22'd0, coarse_cnt, fine_cnt}, {22'd0, 5'd2, 5'd2});

        // R8: a second start mid-run is ignored, inputs captured at acceptance
        @(negedge clk);
        launch(16'd19, 16'd919, 16'd20, 16'd2);
        repeat (20) @(negedge clk);
        launch(16'd0, 16'd65535, 16'd100, 16'd10);
        agn_ps = 16'd1234; gno_ps = 16'd0;
        wait_done("R8 run");
        chk("R8 first request kept", {22'd0, coarse_cnt, fine_cnt}, {22'd0, 5'd2, 5'd4});
        chk("R8 no overflow", {30'd0, coarse_ovf, fine_ovf}, 32'd0);

        // R7: no further strobe after the ignored start
        begin
            int extra = 0;
            repeat (600) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R7 one strobe per start", 32'(extra), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule